// File: doc/BRIEF.md
# Byte-Addressable Word Bus Interface

This unit sits between a 16-bit processor core and a memory that is organised as 16-bit words. The core works with byte addresses over a 64 KiB space. The memory sees a 15-bit word address and a 16-bit data bus. The core asks for one of three operations: a word read, a word write or a byte write. The unit runs the bus accesses that the operation needs and pulses a completion strobe when the last access has ended.

A byte write is done as a read, a merge and a write. The unit reads the containing word, replaces the addressed byte and writes the whole word back, so the neighbouring byte keeps its value. Word writes are also preceded by a read of the target word by default. The core can drop that read in two ways: with a flag on the request, meant for operations that always overwrite the full word, or by issuing the write directly after a read of the same word, which forms a read-modify-write pair.

One address window, loaded while reset is held, marks memory backed by 8-bit devices. Every access that falls in that window is stretched by a number of wait clocks. The unit counts the clocks spent on the bus and counts slow-region and fast-region accesses separately, so software-visible timing can be measured directly.

Top module: `bytebus_unit`

## Requirements
- R1: An access is slow when its word address (byte address bits [15:1]) lies in the inclusive range [cfg_lo, cfg_hi]. Both bounds are sampled only on clocks where rst_n is low, and later changes to cfg_lo or cfg_hi have no effect.
- R2: Each bus access holds mem_rd or mem_wr high for exactly ACC_CLKS clocks, plus WAIT_SLOW clocks when the access is slow. mem_rd and mem_wr are never high together, and mem_addr stays constant for the whole request.
- R3: req_op 2'b00 (and the spare code 2'b11) is a word read: one read access, after which rd_data holds the addressed word. For a byte read, the core picks the byte itself using address bit 0.
- R4: req_op 2'b01 with req_nopre low is a word write: a read access of the target word, followed by a write access of req_wdata to the same word.
- R5: req_op 2'b01 with req_nopre high performs only the write access, with no pre-read.
- R6: req_op 2'b10 is a byte write. The unit pre-reads the word, then writes it back with req_wdata[7:0] placed in bits [15:8] for an even address (bit 0 = 0) or in bits [7:0] for an odd address. The other byte is kept unchanged. req_nopre has no effect on a byte write.
- R7: A word or byte write is accepted as the very next request after a word read of the same word address. Such a write skips the pre-read, and a byte write merges into the word returned by that read.
- R8: A request is accepted only on a clock where req_valid is high and busy is low. busy rises on the next clock and stays high through the done pulse. done is high for exactly one clock, one clock after the last access ends. req_valid is ignored while busy is high.
- R9: clk_cnt, 32 bits wide, increases by one on every clock on which mem_rd or mem_wr is high.
- R10: cnt_slow increases by one for each completed slow access, and cnt_fast increases by one for each completed fast access.
- R11: When cnt_clr is high, all three counters read zero on the next clock. A clear takes priority over an increment on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; region bounds load while it is low |
| cfg_lo | input | 15 | Lowest word address of the slow region |
| cfg_hi | input | 15 | Highest word address of the slow region |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 00 word read, 01 word write, 10 byte write, 11 word read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write word; byte writes use bits [7:0] |
| req_nopre | input | 1 | Skip the pre-read on a word write |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion strobe |
| rd_data | output | 16 | Word returned by the latest read access |
| mem_addr | output | 15 | Word address to memory |
| mem_rd | output | 1 | Read access strobe |
| mem_wr | output | 1 | Write access strobe |
| mem_wdata | output | 16 | Write data to memory |
| mem_rdata | input | 16 | Read data from memory, sampled on the last clock of a read access |
| cnt_clr | input | 1 | Clear all counters |
| clk_cnt | output | 32 | Clocks spent with a bus strobe high |
| cnt_slow | output | 16 | Completed slow-region accesses |
| cnt_fast | output | 16 | Completed fast-region accesses |

## Verification
The assertions rely on some assumptions about the inputs. The slow-region bounds must be stable while reset is held. ACC_CLKS must be at least one. One access must fit in the checker's run-length counter. mem_rdata may take any value, and the strobe length checks depend only on the region decision latched at acceptance. The stimulus holds the bounds steady through reset and then moves them, so that the sampling-only-in-reset rule is exposed. Requests are issued only while busy is low, except for one deliberate request made during a busy period to show that it is dropped. The sweep runs each operation and flag against addresses on both sides of each region edge, at even and odd byte offsets, and orders the requests so that both the read-then-write pairing and its absence occur.

// File: rtl/bb_pkg.sv
package bb_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    OP_RD   = 2'b00,
    OP_WRW  = 2'b01,
    OP_WRB  = 2'b10,
    OP_RDX  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_RD,
    ST_WR,
    ST_FIN
  } st_e;

  // clocks one bus access occupies
  function automatic int acc_len(input logic slow, input int base, input int extra);
    return slow ? base + extra : base;
  endfunction

  // inclusive window test on word addresses
  function automatic logic in_window(input int unsigned w, input int unsigned lo,
                                     input int unsigned hi);
    return (w >= lo) && (w <= hi);
  endfunction

  // even byte address is the upper half of the word
  function automatic logic [WORD_W-1:0] merge_byte(input logic [WORD_W-1:0] old_w,
                                                   input logic [7:0] b,
                                                   input logic odd);
    return odd ? {old_w[WORD_W-1:8], b} : {b, old_w[7:0]};
  endfunction

  function automatic logic op_is_write(input logic [1:0] op);
    return (op == OP_WRW) || (op == OP_WRB);
  endfunction

endpackage

// File: rtl/bb_region.sv
module bb_region #(
  parameter int WAW = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [WAW-1:0] cfg_lo,
  input  logic [WAW-1:0] cfg_hi,
  input  logic [WAW-1:0] waddr,
  output logic           slow_hit
);
  logic [WAW-1:0] lo_q, hi_q;

  // bounds follow the inputs only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= cfg_lo;
      hi_q <= cfg_hi;
    end
  end

  assign slow_hit = bb_pkg::in_window(32'(waddr), 32'(lo_q), 32'(hi_q));
endmodule

// File: rtl/bb_seq.sv
module bb_seq #(
  parameter int ACC_CLKS  = 2,
  parameter int WAIT_SLOW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] op,
  input  logic       skip_pre,
  input  logic       slow,
  output logic       busy,
  output logic       done,
  output logic       rd_strobe,
  output logic       wr_strobe,
  output logic       acc_end,
  output logic       rd_end,
  output logic       rdop_end
);
  import bb_pkg::*;

  localparam int MAX_LEN = ACC_CLKS + WAIT_SLOW;
  localparam int TW      = $clog2(MAX_LEN + 1);

  st_e            st_q, st_d;
  logic [TW-1:0]  tick_q;
  logic           in_acc;
  logic           last;

  assign in_acc = (st_q == ST_PRE) || (st_q == ST_RD) || (st_q == ST_WR);
  assign last   = in_acc && (int'(tick_q) == acc_len(slow, ACC_CLKS, WAIT_SLOW) - 1);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (!op_is_write(op)) st_d = ST_RD;
          else if (skip_pre)    st_d = ST_WR;
          else                  st_d = ST_PRE;
        end
      end
      ST_PRE:  if (last) st_d = ST_WR;
      ST_RD:   if (last) st_d = ST_FIN;
      ST_WR:   if (last) st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tick_q <= '0;
    end else begin
      st_q <= st_d;
      if (!in_acc || last) tick_q <= '0;
      else                 tick_q <= tick_q + 1'b1;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_FIN);
  assign rd_strobe = (st_q == ST_PRE) || (st_q == ST_RD);
  assign wr_strobe = (st_q == ST_WR);
  assign acc_end   = last;
  assign rd_end    = last && rd_strobe;
  assign rdop_end  = last && (st_q == ST_RD);
endmodule

// File: rtl/bb_merge.sv
module bb_merge (
  input  logic        is_byte,
  input  logic        odd,
  input  logic [15:0] old_word,
  input  logic [15:0] new_data,
  output logic [15:0] out_word
);
  always_comb begin
    if (is_byte) out_word = bb_pkg::merge_byte(old_word, new_data[7:0], odd);
    else         out_word = new_data;
  end
endmodule

// File: rtl/bb_counters.sv
module bb_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bus_active,
  input  logic             acc_end,
  input  logic             acc_slow,
  output logic [31:0]      clk_cnt,
  output logic [CNT_W-1:0] cnt_slow,
  output logic [CNT_W-1:0] cnt_fast
);
  logic [CNT_W-1:0] acc_cnt [2];

  always_ff @(posedge clk) begin
    if (!rst_n || clr)   clk_cnt <= '0;
    else if (bus_active) clk_cnt <= clk_cnt + 32'd1;
  end

  // index 1 counts slow accesses, index 0 fast ones
  for (genvar g = 0; g < 2; g++) begin : g_acc
    logic hit;
    assign hit = acc_end && (acc_slow == (g == 1));
    always_ff @(posedge clk) begin
      if (!rst_n || clr) acc_cnt[g] <= '0;
      else if (hit)      acc_cnt[g] <= acc_cnt[g] + 1'b1;
    end
  end

  assign cnt_slow = acc_cnt[1];
  assign cnt_fast = acc_cnt[0];
endmodule

// File: rtl/bytebus_unit.sv
module bytebus_unit #(
  parameter int AW        = 16,
  parameter int ACC_CLKS  = 2,
  parameter int WAIT_SLOW = 4,
  parameter int CNT_W     = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-2:0]       cfg_lo,
  input  logic [AW-2:0]       cfg_hi,
  input  logic                req_valid,
  input  logic [1:0]          req_op,
  input  logic [AW-1:0]       req_addr,
  input  logic [15:0]         req_wdata,
  input  logic                req_nopre,
  output logic                busy,
  output logic                done,
  output logic [15:0]         rd_data,
  output logic [AW-2:0]       mem_addr,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [15:0]         mem_wdata,
  input  logic [15:0]         mem_rdata,
  input  logic                cnt_clr,
  output logic [31:0]         clk_cnt,
  output logic [CNT_W-1:0]    cnt_slow,
  output logic [CNT_W-1:0]    cnt_fast
);
  import bb_pkg::*;

  localparam int WAW = AW - 1;

  // named internal events
  logic           accept;
  logic           region_hit;
  logic           follow_hit;
  logic           skip_pre;
  logic           acc_end_w;
  logic           rd_end_w;
  logic           rdop_end_w;

  logic [WAW-1:0] q_waddr;
  logic           q_odd;
  logic [1:0]     q_op;
  logic [15:0]    q_wdata;
  logic           q_slow;
  logic [15:0]    rd_word;
  logic           follow_q;
  logic [WAW-1:0] follow_addr_q;

  assign accept     = req_valid && !busy;
  assign follow_hit = follow_q && op_is_write(req_op) &&
                      (req_addr[AW-1:1] == follow_addr_q);
  assign skip_pre   = ((req_op == OP_WRW) && req_nopre) || follow_hit;

  bb_region #(.WAW(WAW)) u_region (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_lo   (cfg_lo),
    .cfg_hi   (cfg_hi),
    .waddr    (req_addr[AW-1:1]),
    .slow_hit (region_hit)
  );

  bb_seq #(.ACC_CLKS(ACC_CLKS), .WAIT_SLOW(WAIT_SLOW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .op        (req_op),
    .skip_pre  (skip_pre),
    .slow      (q_slow),
    .busy      (busy),
    .done      (done),
    .rd_strobe (mem_rd),
    .wr_strobe (mem_wr),
    .acc_end   (acc_end_w),
    .rd_end    (rd_end_w),
    .rdop_end  (rdop_end_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_waddr <= '0;
      q_odd   <= 1'b0;
      q_op    <= OP_RD;
      q_wdata <= '0;
      q_slow  <= 1'b0;
    end else if (accept) begin
      q_waddr <= req_addr[AW-1:1];
      q_odd   <= req_addr[0];
      q_op    <= req_op;
      q_wdata <= req_wdata;
      q_slow  <= region_hit;
    end
  end

  // word returned by the latest read access (pre-read or plain read)
  always_ff @(posedge clk) begin
    if (!rst_n)        rd_word <= '0;
    else if (rd_end_w) rd_word <= mem_rdata;
  end

  // a completed word read arms the pairing for the very next request
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      follow_q      <= 1'b0;
      follow_addr_q <= '0;
    end else if (accept) begin
      follow_q <= 1'b0;
    end else if (rdop_end_w) begin
      follow_q      <= 1'b1;
      follow_addr_q <= q_waddr;
    end
  end

  bb_merge u_merge (
    .is_byte  (q_op == OP_WRB),
    .odd      (q_odd),
    .old_word (rd_word),
    .new_data (q_wdata),
    .out_word (mem_wdata)
  );

  bb_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cnt_clr),
    .bus_active (mem_rd || mem_wr),
    .acc_end    (acc_end_w),
    .acc_slow   (q_slow),
    .clk_cnt    (clk_cnt),
    .cnt_slow   (cnt_slow),
    .cnt_fast   (cnt_fast)
  );

  assign mem_addr = q_waddr;
  assign rd_data  = rd_word;
endmodule

// File: rtl/bb_checks.sv
module bb_checks #(
  parameter int WAW       = 15,
  parameter int ACC_CLKS  = 2,
  parameter int WAIT_SLOW = 4,
  parameter int CNT_W     = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic [WAW-1:0]   mem_addr,
  input logic             cnt_clr,
  input logic [31:0]      clk_cnt,
  input logic [CNT_W-1:0] cnt_slow,
  input logic [CNT_W-1:0] cnt_fast,
  input logic             acc_end,
  input logic             acc_slow
);
  logic [1:0]  prev_q;
  logic [15:0] run_q;
  logic [1:0]  strobe_now;

  assign strobe_now = {mem_rd, mem_wr};

  // length of the current run of one strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 2'b00;
      run_q  <= '0;
    end else begin
      prev_q <= strobe_now;
      if (strobe_now == prev_q) run_q <= run_q + 16'd1;
      else                      run_q <= 16'd1;
    end
  end

  p_rd_wr_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_access_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_q != 2'b00 && strobe_now != prev_q) |->
      (int'(run_q) == bb_pkg::acc_len(acc_slow, ACC_CLKS, WAIT_SLOW)));

  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));

  p_clk_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && (mem_rd || mem_wr)) |=> (clk_cnt == $past(clk_cnt) + 32'd1));

  p_slow_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && acc_end && acc_slow) |=> (cnt_slow == $past(cnt_slow) + 1'b1));

  p_fast_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && acc_end && !acc_slow) |=> (cnt_fast == $past(cnt_fast) + 1'b1));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (clk_cnt == 32'd0 && cnt_slow == '0 && cnt_fast == '0));
endmodule

bind bytebus_unit bb_checks #(
  .WAW(AW - 1), .ACC_CLKS(ACC_CLKS), .WAIT_SLOW(WAIT_SLOW), .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_addr (mem_addr),
  .cnt_clr  (cnt_clr),
  .clk_cnt  (clk_cnt),
  .cnt_slow (cnt_slow),
  .cnt_fast (cnt_fast),
  .acc_end  (acc_end_w),
  .acc_slow (q_slow)
);

// File: tb/bytebus_unit_tb.sv
`timescale 1ns/1ps
module bytebus_unit_tb;
  localparam int FASTL = 2;
  localparam int SLOWL = 6;
  localparam logic [14:0] LO = 15'h1000;
  localparam logic [14:0] HI = 15'h17FF;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, req_valid, req_nopre, cnt_clr;
  logic [14:0] cfg_lo, cfg_hi, mem_addr;
  logic [1:0]  req_op;
  logic [15:0] req_addr, req_wdata, rd_data, mem_wdata, mem_rdata;
  logic        busy, done, mem_rd, mem_wr;
  logic [31:0] clk_cnt;
  logic [15:0] cnt_slow, cnt_fast;

  bytebus_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_nopre(req_nopre), .busy(busy), .done(done),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cnt_clr(cnt_clr),
    .clk_cnt(clk_cnt), .cnt_slow(cnt_slow), .cnt_fast(cnt_fast)
  );

  // memory model and reference image, both indexed by word address bits [7:0]
  logic [15:0] bmem [256];
  logic [15:0] ref_img [256];
  assign mem_rdata = bmem[mem_addr[7:0]];

  int rd_tot = 0, wr_tot = 0;
  always @(negedge clk) begin
    if (mem_rd) rd_tot++;
    if (mem_wr) begin
      wr_tot++;
      bmem[mem_addr[7:0]] = mem_wdata;
    end
  end

  int checks = 0, errors = 0;
  int exp_clk = 0, exp_slow = 0, exp_fast = 0;
  logic        last_read = 1'b0;
  logic [14:0] last_rd_w = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, expv);
    end
  endtask

  function automatic logic is_slow(input logic [14:0] w);
    return (w >= LO) && (w <= HI);
  endfunction

  // issue one request and check it; intr=1 tries a second request while busy
  task automatic do_req(input logic [1:0] op, input logic [15:0] a, input logic [15:0] wd,
                        input logic np, input logic intr);
    logic [14:0] w;
    logic        slow, follow, wr;
    int          len, rdx, wrx, r0, w0, k;
    logic [15:0] expw;
    w      = a[15:1];
    slow   = is_slow(w);
    len    = slow ? SLOWL : FASTL;
    wr     = (op == 2'b01) || (op == 2'b10);
    follow = wr && last_read && (last_rd_w == w);
    rdx    = !wr ? len : ((op == 2'b01 && np) || follow) ? 0 : len;
    wrx    = wr ? len : 0;
    @(negedge clk);
    while (busy) @(negedge clk);
    r0 = rd_tot; w0 = wr_tot;
    req_op = op; req_addr = a; req_wdata = wd; req_nopre = np; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    if (intr) begin
      req_op = 2'b01; req_addr = 16'h0040; req_wdata = 16'hDEAD; req_nopre = 1'b1;
      req_valid = 1'b1;
    end
    while (!done && k < 200) begin
      @(negedge clk);
      k++;
      if (intr && k == 3) req_valid = 1'b0;
    end
    chk("R8 latency accept to done", k, rdx + wrx + 1);
    chk("R8 busy during done", busy, 1);
    chk(wr ? ((op == 2'b01 && np) ? "R5 no pre-read clocks" :
              follow ? "R7 paired write pre-read clocks" :
              (op == 2'b10) ? "R6 byte pre-read clocks" : "R4 pre-read clocks")
           : "R3 read clocks", rd_tot - r0, rdx);
    chk(slow ? "R2 slow write clocks" : "R2 fast write clocks", wr_tot - w0, wrx);
    if (!wr) begin
      chk("R3 read data", rd_data, ref_img[w[7:0]]);
    end else begin
      expw = (op == 2'b01) ? wd : (a[0] ? {ref_img[w[7:0]][15:8], wd[7:0]}
                                        : {wd[7:0], ref_img[w[7:0]][7:0]});
      ref_img[w[7:0]] = expw;
      chk(op == 2'b10 ? "R6 merged word" : "R4 written word", bmem[w[7:0]], expw);
    end
    exp_clk += rdx + wrx;
    if (slow) exp_slow += (rdx + wrx) / len; else exp_fast += (rdx + wrx) / len;
    last_read = !wr;
    last_rd_w = w;
    @(negedge clk);
    chk("R8 done one clock", done, 0);
    chk("R8 busy drops", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [14:0] words [5];
    words = '{15'h0005, 15'h0FFF, 15'h1000, 15'h17FF, 15'h1800};
    for (int i = 0; i < 256; i++) begin
      bmem[i]    = 16'(i * 16'h0101) ^ 16'h5A3C;
      ref_img[i] = bmem[i];
    end
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00; req_addr = '0; req_wdata = '0;
    req_nopre = 1'b0; cnt_clr = 1'b0; cfg_lo = LO; cfg_hi = HI;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: bounds move after reset and must not be picked up
    cfg_lo = 15'h0000; cfg_hi = 15'h7FFF;
    @(negedge clk);
    chk("R8 reset busy", busy, 0);
    chk("R8 reset done", done, 0);
    chk("R2 reset strobes", {mem_rd, mem_wr}, 0);
    chk("R9 reset clk_cnt", clk_cnt, 0);
    chk("R10 reset access counts", {cnt_slow, cnt_fast}, 0);

    // R1 edges swept with every operation and both byte offsets
    for (int i = 0; i < 5; i++) begin
      for (int b = 0; b < 2; b++) begin
        logic [15:0] a;
        a = {words[i], b[0]};
        do_req(2'b01, a, 16'h1234 ^ a, 1'b0, 1'b0);
        do_req(2'b01, a, 16'hC0DE + a, 1'b1, 1'b0);
        do_req(2'b10, a, 16'h00A5 + 16'(i), b[0], 1'b0);
        do_req(b[0] ? 2'b11 : 2'b00, a, 16'h0, 1'b0, 1'b0);
        do_req(2'b10, a, 16'h003C, 1'b0, 1'b0);
        do_req(2'b00, a, 16'h0, 1'b0, 1'b0);
        do_req(2'b01, a, 16'h7E81, 1'b0, 1'b0);
      end
    end
    // R7: a read of another word does not pair with the write
    do_req(2'b00, 16'h0010, 16'h0, 1'b0, 1'b0);
    do_req(2'b01, 16'h0012, 16'hBEEF, 1'b0, 1'b0);
    // R8: request raised while busy is dropped
    do_req(2'b01, 16'h2010, 16'h4242, 1'b1, 1'b1);
    chk("R8 ignored request left memory", bmem[8'h20], ref_img[8'h20]);

    @(negedge clk);
    chk("R9 clock total", clk_cnt, exp_clk);
    chk("R10 slow accesses", cnt_slow, exp_slow);
    chk("R10 fast accesses", cnt_fast, exp_fast);
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    chk("R11 clear", {clk_cnt, cnt_slow, cnt_fast}, 0);
    exp_clk = 0; exp_slow = 0; exp_fast = 0;
    do_req(2'b10, 16'h2001, 16'h0011, 1'b0, 1'b0);
    chk("R9 clocks after clear", clk_cnt, exp_clk);
    chk("R10 slow after clear", cnt_slow, exp_slow);
    chk("R10 fast after clear", cnt_fast, exp_fast);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule